// File: doc/BRIEF.md
# Receive Elasticity Buffer

This block moves a serial receive bit stream from a recovered line clock into the local 50 MHz reference clock domain. It absorbs the frequency drift that builds up over one packet. Bits arrive one per recovered-clock cycle while `rx_valid_i` is high, and a packet ends when that flag drops. The buffer holds back the start of each packet until a pre-fill level is reached. It then sends one bit per reference cycle with `out_valid_o` until the last bit of the packet has left.

A 2-bit code selects how many bits of drift the buffer tolerates. The code is non-monotonic: 01 = 2 bits, 10 = 6 bits, 11 = 10 bits and 00 = 14 bits. The pre-fill is half of the selected tolerance. Larger settings allow longer packets at a given ppm offset, and they cost more latency. Two sticky flags report faults. One flags a write that found the storage full, and the other flags a read, inside a packet, that found it empty. A one-cycle pulse on `clr_i` clears both flags.

Top module: `rx_elbuf`

## Requirements
- R1: After reset, `out_valid_o`, `ovf_o` and `unf_o` are 0, and the active tolerance code `tol_act_o` is 01.
- R2: Every packet bit is delivered exactly once, in arrival order, on `out_data_o` with `out_valid_o` high. The number of delivered bits equals the packet length when no overflow occurs.
- R3: Output of a packet starts once the buffer holds at least the pre-fill count. The pre-fill is 1, 3, 5 and 7 bits for codes 01, 10, 11 and 00. With both clocks at equal rate, each step up in pre-fill delays the first output bit by exactly 2 reference cycles.
- R4: A packet shorter than the pre-fill count is still delivered in full, because the end of the packet releases it.
- R5: `tol_sel_i` is sampled only at the start of a packet, and `tol_act_o` shows the sampled code. A change during a packet does not alter `tol_act_o` or the pre-fill until the next packet starts.
- R6: A bit that arrives while the storage (32 entries) is full is dropped, and `ovf_o` goes to 1. The flag stays at 1 until cleared.
- R7: A read slot inside a packet that finds the buffer empty sets `unf_o` to 1 and leaves `out_valid_o` low for that cycle. The flag is sticky, and the bits that are delivered keep their order.
- R8: A one-cycle pulse on `clr_i` clears `ovf_o` and `unf_o`. A new fault in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk_i | input | 1 | Recovered receive bit clock |
| rx_valid_i | input | 1 | High while packet bits arrive; falling edge marks packet end |
| rx_data_i | input | 1 | Received bit |
| ref_clk_i | input | 1 | Local 50 MHz reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| tol_sel_i | input | 2 | Drift tolerance code (01=2, 10=6, 11=10, 00=14 bits) |
| clr_i | input | 1 | Clears both sticky fault flags (reference domain) |
| out_valid_o | output | 1 | Output bit valid |
| out_data_o | output | 1 | Output bit |
| tol_act_o | output | 2 | Tolerance code latched at the current packet start |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |

## Verification
The assertions assume that `clr_i` is synchronous to the reference clock, and that `rx_valid_i` drops for at least one recovered-clock cycle between packets. The one-idle-slot gap that the read side inserts after each packet therefore separates back-to-back output bursts. The stimulus drives every input on the falling edge of its own clock and always ends a packet with at least one idle bit time. It changes the recovered clock period only while the buffer is idle, so the pointer synchronizers never see a mid-packet period step.

// File: rtl/rx_elbuf_pkg.sv
package rx_elbuf_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_STREAM} rd_state_e;

  // pre-fill = half the drift tolerance selected by the code
  function automatic logic [4:0] half_tol(input logic [1:0] code);
    unique case (code)
      2'b00:   half_tol = 5'd7;
      2'b01:   half_tol = 5'd1;
      2'b10:   half_tol = 5'd3;
      default: half_tol = 5'd5;
    endcase
  endfunction
endpackage

// File: rtl/rx_elbuf_sync.sv
module rx_elbuf_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/rx_elbuf_wr.sv
module rx_elbuf_wr #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic                  data_i,
  input  logic [AW:0]           rgray_i,
  input  logic                  ovf_ack_i,
  output logic [DEPTH-1:0][1:0] mem_o,
  output logic [AW:0]           wgray_o,
  output logic                  ovf_pend_o
);
  logic [AW:0] wptr_q, wptr_nxt, rptr_bin;
  logic        hold_v_q, hold_d_q;
  logic        full, do_wr, drop;

  always_comb begin
    rptr_bin[AW] = rgray_i[AW];
    for (int i = AW - 1; i >= 0; i--) rptr_bin[i] = rptr_bin[i+1] ^ rgray_i[i];
  end

  assign full     = (wptr_q[AW] != rptr_bin[AW]) && (wptr_q[AW-1:0] == rptr_bin[AW-1:0]);
  assign do_wr    = hold_v_q && !full;
  // a pending end-of-packet entry waits for room; only data bits are dropped
  assign drop     = hold_v_q && full && valid_i;
  assign wptr_nxt = wptr_q + (AW+1)'(do_wr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_o      <= '0;
      wptr_q     <= '0;
      wgray_o    <= '0;
      hold_v_q   <= 1'b0;
      hold_d_q   <= 1'b0;
      ovf_pend_o <= 1'b0;
    end else begin
      if (do_wr) mem_o[wptr_q[AW-1:0]] <= {~valid_i, hold_d_q};  // [1] = last bit
      wptr_q  <= wptr_nxt;
      wgray_o <= wptr_nxt ^ (wptr_nxt >> 1);
      if (valid_i) begin
        hold_v_q <= 1'b1;
        hold_d_q <= data_i;
      end else if (do_wr) begin
        hold_v_q <= 1'b0;
      end
      if (drop && !ovf_ack_i)  ovf_pend_o <= 1'b1;
      else if (ovf_ack_i)      ovf_pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_elbuf_rd.sv
module rx_elbuf_rd
  import rx_elbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DEPTH-1:0][1:0] mem_i,
  input  logic [AW:0]           wgray_i,
  input  logic [1:0]            tol_sel_i,
  input  logic                  clr_i,
  input  logic                  ovf_pend_i,
  output logic [AW:0]           rgray_o,
  output logic                  ovf_ack_o,
  output logic                  out_valid_o,
  output logic                  out_data_o,
  output logic [1:0]            tol_act_o,
  output logic                  ovf_o,
  output logic                  unf_o
);
  localparam int FW = AW + 1;

  rd_state_e   state_q, state_d;
  logic [AW:0] rptr_q, rptr_nxt, wptr_bin, fill;
  logic [AW-1:0] tail_idx;
  logic [1:0]  head, tol_d;
  logic        empty, tail_last, rd_en, unf_evt, ovf_evt;
  logic [4:0]  thr_new, thr_act;

  always_comb begin
    wptr_bin[AW] = wgray_i[AW];
    for (int i = AW - 1; i >= 0; i--) wptr_bin[i] = wptr_bin[i+1] ^ wgray_i[i];
  end

  assign fill      = wptr_bin - rptr_q;
  assign empty     = (fill == '0);
  assign tail_idx  = wptr_bin[AW-1:0] - AW'(1);
  assign tail_last = !empty && mem_i[tail_idx][1];
  assign head      = mem_i[rptr_q[AW-1:0]];
  assign thr_new   = half_tol(tol_sel_i);
  assign thr_act   = half_tol(tol_act_o);
  assign ovf_evt   = ovf_pend_i && !ovf_ack_o;

  always_comb begin
    state_d = state_q;
    tol_d   = tol_act_o;
    rd_en   = 1'b0;
    unf_evt = 1'b0;
    unique case (state_q)
      ST_IDLE: if (!empty) begin
        tol_d = tol_sel_i;  // code sampled only here, at packet start
        if (fill >= FW'(thr_new) || tail_last) state_d = ST_STREAM;
        else                                   state_d = ST_FILL;
      end
      ST_FILL: if (fill >= FW'(thr_act) || tail_last) state_d = ST_STREAM;
      default: begin
        rd_en   = !empty;
        unf_evt = empty;
        if (rd_en && head[1]) state_d = ST_IDLE;
      end
    endcase
  end

  assign rptr_nxt = rptr_q + FW'(rd_en);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      rptr_q      <= '0;
      rgray_o     <= '0;
      tol_act_o   <= 2'b01;
      out_valid_o <= 1'b0;
      out_data_o  <= 1'b0;
      ovf_ack_o   <= 1'b0;
      ovf_o       <= 1'b0;
      unf_o       <= 1'b0;
    end else begin
      state_q     <= state_d;
      tol_act_o   <= tol_d;
      rptr_q      <= rptr_nxt;
      rgray_o     <= rptr_nxt ^ (rptr_nxt >> 1);
      out_valid_o <= rd_en;
      if (rd_en) out_data_o <= head[0];
      ovf_ack_o   <= ovf_pend_i;
      if (ovf_evt)    ovf_o <= 1'b1;
      else if (clr_i) ovf_o <= 1'b0;
      if (unf_evt)    unf_o <= 1'b1;
      else if (clr_i) unf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_elbuf.sv
module rx_elbuf #(
  parameter int DEPTH = 32
) (
  input  logic       rx_clk_i,
  input  logic       rx_valid_i,
  input  logic       rx_data_i,
  input  logic       ref_clk_i,
  input  logic       rst_ni,
  input  logic [1:0] tol_sel_i,
  input  logic       clr_i,
  output logic       out_valid_o,
  output logic       out_data_o,
  output logic [1:0] tol_act_o,
  output logic       ovf_o,
  output logic       unf_o
);
  localparam int AW = $clog2(DEPTH);

  logic [DEPTH-1:0][1:0] mem;
  logic [AW:0] wgray, wgray_s, rgray, rgray_s;
  logic        ovf_pend, ovf_pend_s, ovf_ack, ovf_ack_s;

  rx_elbuf_wr #(.DEPTH(DEPTH), .AW(AW)) u_wr (
    .clk_i(rx_clk_i), .rst_ni(rst_ni), .valid_i(rx_valid_i), .data_i(rx_data_i),
    .rgray_i(rgray_s), .ovf_ack_i(ovf_ack_s),
    .mem_o(mem), .wgray_o(wgray), .ovf_pend_o(ovf_pend)
  );

  rx_elbuf_sync #(.W(AW+1)) u_sync_wptr (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .d_i(wgray), .q_o(wgray_s));
  rx_elbuf_sync #(.W(1)) u_sync_pend (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .d_i(ovf_pend), .q_o(ovf_pend_s));
  rx_elbuf_sync #(.W(AW+1)) u_sync_rptr (
    .clk_i(rx_clk_i), .rst_ni(rst_ni), .d_i(rgray), .q_o(rgray_s));
  rx_elbuf_sync #(.W(1)) u_sync_ack (
    .clk_i(rx_clk_i), .rst_ni(rst_ni), .d_i(ovf_ack), .q_o(ovf_ack_s));

  rx_elbuf_rd #(.DEPTH(DEPTH), .AW(AW)) u_rd (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .mem_i(mem), .wgray_i(wgray_s),
    .tol_sel_i(tol_sel_i), .clr_i(clr_i), .ovf_pend_i(ovf_pend_s),
    .rgray_o(rgray), .ovf_ack_o(ovf_ack), .out_valid_o(out_valid_o),
    .out_data_o(out_data_o), .tol_act_o(tol_act_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );
endmodule

// File: rtl/rx_elbuf_chk.sv
module rx_elbuf_chk (
  input logic       ref_clk_i,
  input logic       rst_ni,
  input logic       clr_i,
  input logic       out_valid_o,
  input logic [1:0] tol_act_o,
  input logic       ovf_o,
  input logic       unf_o
);
  AST_OVF_STICKY: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    ovf_o && !clr_i |=> ovf_o);  // R6
  AST_UNF_STICKY: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    unf_o && !clr_i |=> unf_o);  // R7
  AST_UNF_GAP: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $rose(unf_o) |-> !out_valid_o);  // R7
  AST_TOL_HELD: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    out_valid_o && $past(out_valid_o) |-> $stable(tol_act_o));  // R5
  AST_CLR_TAKES: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $fell(ovf_o) |-> $past(clr_i));  // R8
endmodule

bind rx_elbuf rx_elbuf_chk u_chk (
  .ref_clk_i(ref_clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .out_valid_o(out_valid_o),
  .tol_act_o(tol_act_o), .ovf_o(ovf_o), .unf_o(unf_o)
);

// File: tb/test_rx_elbuf.sv
`timescale 1ns/1ps
module test_rx_elbuf;
  logic       rx_clk = 1'b0, ref_clk = 1'b0, rst_ni = 1'b0;
  logic       rx_valid = 1'b0, rx_data = 1'b0, clr = 1'b0;
  logic [1:0] tol_sel = 2'b01;
  logic       out_valid, out_data, ovf, unf;
  logic [1:0] tol_act;
  real        rx_half = 4.0;

  int n_run = 0, n_fail = 0, cyc = 0, rcv_n = 0;
  logic rcv_bits [0:1023];
  int   rcv_cyc  [0:1023];
  int   start_cyc = 0;
  int   lat [0:3];

  rx_elbuf i_rx_elbuf (
    .rx_clk_i(rx_clk), .rx_valid_i(rx_valid), .rx_data_i(rx_data), .ref_clk_i(ref_clk),
    .rst_ni(rst_ni), .tol_sel_i(tol_sel), .clr_i(clr),
    .out_valid_o(out_valid), .out_data_o(out_data), .tol_act_o(tol_act),
    .ovf_o(ovf), .unf_o(unf)
  );

  always #4 ref_clk = ~ref_clk;  // 125 MHz
  initial begin
    #3;
    forever #(rx_half) rx_clk = ~rx_clk;
  end
  always @(posedge ref_clk) cyc++;

  always @(negedge ref_clk) begin
    if (rst_ni && out_valid) begin
      if (rcv_n < 1024) begin
        rcv_bits[rcv_n] = out_data;
        rcv_cyc[rcv_n]  = cyc;
      end
      rcv_n++;
    end
  end

  // {tol code, length, pattern}
  localparam int NV = 7;
  localparam logic [41:0] VEC [NV] = '{
    {2'b01, 8'd40, 32'hA5C3_1E77},
    {2'b10, 8'd40, 32'h1234_5678},
    {2'b11, 8'd40, 32'hF0F0_0F0F},
    {2'b00, 8'd40, 32'hDEAD_BEEF},
    {2'b00, 8'd1,  32'h0000_0001},
    {2'b11, 8'd3,  32'h0000_0005},
    {2'b01, 8'd2,  32'h0000_0002}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_pkt(input int len, input logic [31:0] pat);
    for (int i = 0; i < len; i++) begin
      @(negedge rx_clk);
      if (i == 0) start_cyc = cyc;
      rx_valid = 1'b1;
      rx_data  = pat[i % 32];
    end
    @(negedge rx_clk);
    rx_valid = 1'b0;
    rx_data  = 1'b0;
  endtask

  task automatic chk_data(input int base, input int len, input logic [31:0] pat, input string req);
    int bad = 0;
    for (int i = 0; i < len; i++)
      if (rcv_bits[base+i] !== pat[i % 32]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic pulse_clr();
    @(negedge ref_clk) clr = 1'b1;
    @(negedge ref_clk) clr = 1'b0;
    @(negedge ref_clk);
  endtask

  initial begin
    repeat (150000) @(posedge ref_clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int base;
    repeat (5) @(negedge ref_clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge ref_clk);
    chk(out_valid == 1'b0, "R1 valid", out_valid, 0);
    chk(ovf == 1'b0, "R1 ovf", ovf, 0);
    chk(unf == 1'b0, "R1 unf", unf, 0);
    chk(tol_act == 2'b01, "R1 tol_act", tol_act, 1);

    // table: equal clock rates, one packet per row
    for (int v = 0; v < NV; v++) begin
      int len;
      tol_sel = VEC[v][41:40];
      len     = int'(VEC[v][39:32]);
      base    = rcv_n;
      send_pkt(len, VEC[v][31:0]);
      repeat (60) @(negedge ref_clk);
      chk(rcv_n - base == len, (len < 8) ? "R4 count" : "R2 count", rcv_n - base, len);
      chk_data(base, len, VEC[v][31:0], (len < 8) ? "R4 data" : "R2 data");
      chk(tol_act == VEC[v][41:40], "R5 tol_act", tol_act, int'(VEC[v][41:40]));
      if (v < 4) lat[v] = rcv_cyc[base] - start_cyc;
    end
    for (int v = 1; v < 4; v++)
      chk(lat[v] - lat[v-1] == 2, "R3 prefill step", lat[v] - lat[v-1], 2);
    chk(ovf == 1'b0 && unf == 1'b0, "R6 R7 no fault", {ovf, unf}, 0);

    // R5: code change inside a packet
    tol_sel = 2'b01;
    base = rcv_n;
    fork
      send_pkt(60, 32'h3C5A_9617);
      begin
        repeat (30) @(negedge ref_clk);
        tol_sel = 2'b00;
        repeat (5) @(negedge ref_clk);
        chk(tol_act == 2'b01, "R5 mid-packet", tol_act, 1);
      end
    join
    repeat (60) @(negedge ref_clk);
    chk(tol_act == 2'b01, "R5 idle hold", tol_act, 1);
    chk_data(base, 60, 32'h3C5A_9617, "R5 data");
    base = rcv_n;
    send_pkt(8, 32'h0000_00B4);
    repeat (40) @(negedge ref_clk);
    chk(tol_act == 2'b00, "R5 next packet", tol_act, 0);
    chk(rcv_n - base == 8, "R5 count", rcv_n - base, 8);

    // R7: slow recovered clock starves the reader
    rx_half = 6.0;
    tol_sel = 2'b01;
    repeat (10) @(negedge ref_clk);
    base = rcv_n;
    send_pkt(40, 32'h9E37_79B9);
    repeat (100) @(negedge ref_clk);
    chk(unf == 1'b1, "R7 set", unf, 1);
    chk(rcv_n - base == 40, "R7 count", rcv_n - base, 40);
    chk_data(base, 40, 32'h9E37_79B9, "R7 order");
    repeat (20) @(negedge ref_clk);
    chk(unf == 1'b1, "R7 sticky", unf, 1);
    chk(ovf == 1'b0, "R7 no ovf", ovf, 0);
    pulse_clr();
    chk(unf == 1'b0, "R8 clear unf", unf, 0);

    // R6: fast recovered clock fills the storage
    rx_half = 2.0;
    tol_sel = 2'b00;
    repeat (10) @(negedge ref_clk);
    base = rcv_n;
    send_pkt(120, 32'h5555_AAAA);
    repeat (200) @(negedge ref_clk);
    chk(ovf == 1'b1, "R6 set", ovf, 1);
    chk(rcv_n - base < 120, "R6 drop", rcv_n - base, 119);
    chk(rcv_n - base >= 32, "R6 delivered", rcv_n - base, 32);
    repeat (20) @(negedge ref_clk);
    chk(ovf == 1'b1, "R6 sticky", ovf, 1);
    pulse_clr();
    chk(ovf == 1'b0, "R8 clear ovf", ovf, 0);
    chk(out_valid == 1'b0, "R6 drained", out_valid, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule